// File: doc/BRIEF.md
# Store Merge Latch

This block is a single-entry holding stage in front of a write buffer FIFO. Processor stores arrive with a byte address, byte-lane enables, data and a region coherency attribute. The most recent store is held in the latch. A later store to the same 32-bit word folds its enabled bytes into the held entry when merging is allowed. A store to another word, or one that may not merge, displaces the held entry into the FIFO and takes its place.

Each entry pushed into the FIFO carries an end-of-run flag. The downstream burst logic uses this flag to find where a run of consecutive words stops. The flag is cleared only when the store that displaces the entry targets the next sequential word, that word stays inside the same 32-byte aligned block, and the run is shorter than its word limit. A flush input drains the latch and always marks its entry as the end of a run. When the FIFO cannot accept an entry, the store handshake stalls. A store that only merges never needs the FIFO, so it is accepted anyway.

Merging is controlled at two levels: a global no-merge configuration bit, written through a small write port, and a per-store region attribute.

Top module: `store_merge_latch`

## Requirements
- R1: After reset the latch is empty, `fifo_push` is 0, `st_ready` is 1 and the no-merge configuration bit is 0, so merging is enabled.
- R2: A store to the held word is merged when merging is allowed. Only its enabled byte lanes overwrite the held data, the held byte mask becomes the OR of both masks, and nothing is pushed.
- R3: While the no-merge bit is 1, a store to the held word is never merged, whatever its attribute. The held entry is pushed with the end flag set.
- R4: While the no-merge bit is 0, a store whose attribute equals 2 never merges and displaces the held entry. Any other attribute value merges.
- R5: A store to a different word pushes the held entry and loads the new store into the latch. The pushed address is word aligned (bits 1:0 are zero). A store never merges with an entry already pushed: byte stores to 0x1000, 0x1005 and 0x1002 yield three separate entries.
- R6: The end flag of a displaced entry is 0 only if the displacing store's word address equals the held word address plus 4. Otherwise it is 1.
- R7: The end flag is forced to 1 when the next sequential word would start a new 32-byte aligned block. It is also forced to 1 when the entry would be the eighth word of the run, so a run never exceeds 8 words.
- R8: While `flush` is 1, stores are not accepted (`st_ready` is 0). A held entry is pushed with the end flag set and the latch empties. With the latch empty, a flush pushes nothing.
- R9: When a push is needed and `fifo_ready` is 0, `st_ready` is 0 and the latch keeps its entry. A merging store is still accepted.
- R10: With no store and no flush, the held entry stays unchanged in the latch and nothing is pushed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Write strobe for the no-merge configuration bit |
| cfg_no_merge | input | 1 | Value written to the no-merge bit |
| st_valid | input | 1 | Store request valid |
| st_ready | output | 1 | Store request accepted this cycle |
| st_addr | input | 32 | Store byte address |
| st_be | input | 4 | Store byte-lane enables (bit i = bits 8i+7:8i) |
| st_data | input | 32 | Store data |
| st_cca | input | 3 | Region coherency attribute of the store |
| flush | input | 1 | Drain the latch into the FIFO |
| fifo_ready | input | 1 | FIFO can accept an entry |
| fifo_push | output | 1 | Entry is written into the FIFO this cycle |
| fifo_addr | output | 32 | Word-aligned address of the pushed entry |
| fifo_be | output | 4 | Byte mask of the pushed entry |
| fifo_data | output | 32 | Data of the pushed entry |
| fifo_end | output | 1 | Pushed entry ends a gatherable run |

## Verification
A corrupted held address or byte mask is not visible right away. It shows up on the FIFO port only when the entry is displaced or flushed, which may be many cycles later. The bench therefore flushes after each scenario, so every held entry is compared against an independent model.

A wrong run counter or boundary decision shows as a wrong `fifo_end` on the first push that follows. A wrong merge decision shows in the same cycle, either as an unexpected push or as a missing one.

// File: rtl/sml_pkg.sv
// Package: shared action encoding for the store merge latch.
// Assumes: one action per cycle, chosen by the top-level decoder.
package sml_pkg;
    typedef enum logic [2:0] {
        ACT_IDLE     = 3'd0,
        ACT_LOAD     = 3'd1,
        ACT_MERGE    = 3'd2,
        ACT_DISPLACE = 3'd3,
        ACT_FLUSH    = 3'd4
    } sml_act_e;
endpackage

// File: rtl/sml_merge_ctl.sv
// Module: decides whether an incoming store may fold into the held entry.
// Assumes: word addresses are already extracted; purely combinational.
module sml_merge_ctl #(
    parameter int WW          = 30,
    parameter int CCA_W       = 3,
    parameter int NOMERGE_CCA = 2
) (
    input  logic             no_merge_cfg,
    input  logic             held_v,
    input  logic [WW-1:0]    held_word,
    input  logic [WW-1:0]    st_word,
    input  logic [CCA_W-1:0] st_cca,
    output logic             merge_ok
);
    logic same_word;
    logic region_allows;

    // Same-word hit against the latch only, never against FIFO contents.
    always_comb same_word = held_v && (st_word == held_word);

    // Region attribute gate, then the global gate over it.
    always_comb region_allows = (st_cca != CCA_W'(NOMERGE_CCA));

    always_comb merge_ok = same_word && !no_merge_cfg && region_allows;
endmodule

// File: rtl/sml_lane_merge.sv
// Module: byte-lane overlay of a new store onto the held entry.
// Assumes: BE lanes of 8 bits each; purely combinational.
module sml_lane_merge #(
    parameter int BE = 4
) (
    input  logic [BE-1:0]   held_be,
    input  logic [8*BE-1:0] held_data,
    input  logic [BE-1:0]   st_be,
    input  logic [8*BE-1:0] st_data,
    output logic [BE-1:0]   mrg_be,
    output logic [8*BE-1:0] mrg_data
);
    // Combined mask covers every lane either store wrote.
    always_comb mrg_be = held_be | st_be;

    for (genvar g = 0; g < BE; g++) begin : g_lane
        // Newer lane wins when enabled, else keep the held byte.
        always_comb mrg_data[8*g +: 8] = st_be[g] ? st_data[8*g +: 8] : held_data[8*g +: 8];
    end
endmodule

// File: rtl/sml_end_gen.sv
// Module: computes the end-of-run flag of a pushed entry and tracks run length.
// Assumes: push is asserted only in the cycle the FIFO takes the entry.
module sml_end_gen #(
    parameter int WW        = 30,
    parameter int BLK_WORDS = 8,
    parameter int RUN_MAX   = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic          follow_valid,
    input  logic [WW-1:0] held_word,
    input  logic [WW-1:0] next_word,
    output logic          end_bit
);
    localparam int BLK_BITS = $clog2(BLK_WORDS);
    localparam int RC_W     = $clog2(RUN_MAX) + 1;

    logic [RC_W-1:0] run_q;
    logic [WW-1:0]   succ_word;
    logic            seq_hit;
    logic            at_blk_top;
    logic            run_full;

    // Address one word above the held entry.
    always_comb succ_word = held_word + WW'(1);

    // Sequential follow-on store only counts when a store displaced the entry.
    always_comb seq_hit = follow_valid && (next_word == succ_word);

    // Held word is the last one of its aligned block.
    always_comb at_blk_top = &held_word[BLK_BITS-1:0];

    // Held word would already be the last allowed word of the run.
    always_comb run_full = (run_q >= RC_W'(RUN_MAX - 1));

    always_comb end_bit = !(seq_hit && !at_blk_top && !run_full);

    // Run length counter: restarts after a run-ending push.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q <= '0;
        end else if (push) begin
            run_q <= end_bit ? '0 : run_q + RC_W'(1);
        end
    end

    // R7: the run counter never passes the word limit.
    p_run_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
        run_q <= RC_W'(RUN_MAX - 1));
endmodule

// File: rtl/store_merge_latch.sv
// Module: single-entry store merge latch feeding a write buffer FIFO.
// Holds one word, folds same-word stores into it, pushes it out with an
// end-of-run flag when displaced or flushed.
// Assumes: stores are word-lane aligned (BE lanes per word); the FIFO
// accepts an entry in any cycle where fifo_ready is 1.
module store_merge_latch
    import sml_pkg::*;
#(
    parameter int AW          = 32,
    parameter int DW          = 32,
    parameter int CCA_W       = 3,
    parameter int NOMERGE_CCA = 2,
    parameter int BLK_BYTES   = 32,
    parameter int RUN_MAX     = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic             cfg_no_merge,
    input  logic             st_valid,
    output logic             st_ready,
    input  logic [AW-1:0]    st_addr,
    input  logic [DW/8-1:0]  st_be,
    input  logic [DW-1:0]    st_data,
    input  logic [CCA_W-1:0] st_cca,
    input  logic             flush,
    input  logic             fifo_ready,
    output logic             fifo_push,
    output logic [AW-1:0]    fifo_addr,
    output logic [DW/8-1:0]  fifo_be,
    output logic [DW-1:0]    fifo_data,
    output logic             fifo_end
);
    localparam int BE        = DW / 8;
    localparam int OFS       = $clog2(BE);
    localparam int WW        = AW - OFS;
    localparam int BLK_WORDS = BLK_BYTES / BE;

    logic             nm_q;
    logic             held_v;
    logic [WW-1:0]    held_word;
    logic [BE-1:0]    held_be;
    logic [DW-1:0]    held_data;

    logic [WW-1:0]    st_word;
    logic             merge_ok;
    logic [BE-1:0]    mrg_be;
    logic [DW-1:0]    mrg_data;
    logic             need_push;
    logic             end_bit;
    sml_act_e         act;

    // Word part of the incoming store address.
    always_comb st_word = st_addr[AW-1:OFS];

    // Global no-merge configuration bit, merging enabled out of reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            nm_q <= 1'b0;
        end else if (cfg_we) begin
            nm_q <= cfg_no_merge;
        end
    end

    sml_merge_ctl #(
        .WW(WW), .CCA_W(CCA_W), .NOMERGE_CCA(NOMERGE_CCA)
    ) u_merge_ctl (
        .no_merge_cfg (nm_q),
        .held_v       (held_v),
        .held_word    (held_word),
        .st_word      (st_word),
        .st_cca       (st_cca),
        .merge_ok     (merge_ok)
    );

    sml_lane_merge #(.BE(BE)) u_lane_merge (
        .held_be   (held_be),
        .held_data (held_data),
        .st_be     (st_be),
        .st_data   (st_data),
        .mrg_be    (mrg_be),
        .mrg_data  (mrg_data)
    );

    // Action decode: flush first, then the store request.
    always_comb begin
        act       = ACT_IDLE;
        need_push = 1'b0;
        if (flush) begin
            if (held_v) begin
                act       = ACT_FLUSH;
                need_push = 1'b1;
            end
        end else if (st_valid) begin
            if (!held_v) begin
                act = ACT_LOAD;
            end else if (merge_ok) begin
                act = ACT_MERGE;
            end else begin
                act       = ACT_DISPLACE;
                need_push = 1'b1;
            end
        end
    end

    // Store handshake: stall only when a push is needed and the FIFO is full.
    always_comb st_ready = !flush && (!held_v || merge_ok || fifo_ready);

    sml_end_gen #(
        .WW(WW), .BLK_WORDS(BLK_WORDS), .RUN_MAX(RUN_MAX)
    ) u_end_gen (
        .clk          (clk),
        .rst_n        (rst_n),
        .push         (fifo_push),
        .follow_valid (act == ACT_DISPLACE),
        .held_word    (held_word),
        .next_word    (st_word),
        .end_bit      (end_bit)
    );

    // FIFO side: present the held entry whenever it leaves.
    always_comb begin
        fifo_push = need_push && fifo_ready;
        fifo_addr = {held_word, {OFS{1'b0}}};
        fifo_be   = held_be;
        fifo_data = held_data;
        fifo_end  = end_bit;
    end

    // Latch update per action.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held_v    <= 1'b0;
            held_word <= '0;
            held_be   <= '0;
            held_data <= '0;
        end else begin
            case (act)
                ACT_LOAD: begin
                    held_v    <= 1'b1;
                    held_word <= st_word;
                    held_be   <= st_be;
                    held_data <= st_data;
                end
                ACT_MERGE: begin
                    held_be   <= mrg_be;
                    held_data <= mrg_data;
                end
                ACT_DISPLACE: begin
                    if (fifo_ready) begin
                        held_word <= st_word;
                        held_be   <= st_be;
                        held_data <= st_data;
                    end
                end
                ACT_FLUSH: begin
                    if (fifo_ready) held_v <= 1'b0;
                end
                default: ;
            endcase
        end
    end

    // R2: an allowed same-word store keeps the entry in place, no push.
    p_merge_keeps_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (st_valid && st_ready && held_v && st_word == held_word && !nm_q
         && st_cca != CCA_W'(NOMERGE_CCA)) |-> !fifo_push ##1 (held_v && held_word == $past(st_word)));

    // R3: global no-merge forces every accepted store against a held entry out.
    p_global_nomerge_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (nm_q && st_valid && st_ready && held_v) |-> fifo_push);

    // R4: the no-merge region attribute displaces the held entry.
    p_region_nomerge_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (st_valid && st_ready && held_v && st_cca == CCA_W'(NOMERGE_CCA)) |-> fifo_push);

    // R8: a flush push ends the run and empties the latch.
    p_flush_end_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (flush && fifo_push) |-> fifo_end ##1 !held_v);

    // R8: no store is accepted during a flush.
    p_flush_blocks_r8: assert property (@(posedge clk) disable iff (!rst_n)
        flush |-> !st_ready);

    // R10: an idle cycle leaves the held entry untouched.
    p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (held_v && !st_valid && !flush) |=> (held_v && $stable(held_word)
         && $stable(held_be) && $stable(held_data)));
endmodule

// File: tb/test_store_merge_latch.sv
// Scoreboard bench: the driver models the latch and queues expected pushes,
// the monitor compares every FIFO push against the queue.
module test_store_merge_latch;
    typedef struct {
        logic [31:0] a;
        logic [3:0]  b;
        logic [31:0] d;
        logic        e;
        string       tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0, cfg_no_merge = 1'b0;
    logic        st_valid = 1'b0;
    logic        st_ready;
    logic [31:0] st_addr = '0;
    logic [3:0]  st_be = '0;
    logic [31:0] st_data = '0;
    logic [2:0]  st_cca = '0;
    logic        flush = 1'b0;
    logic        fifo_ready = 1'b1;
    logic        fifo_push;
    logic [31:0] fifo_addr;
    logic [3:0]  fifo_be;
    logic [31:0] fifo_data;
    logic        fifo_end;

    int   n_chk = 0, n_err = 0;
    bit   done = 0;
    exp_t exp_q[$];

    // model state
    bit          m_v = 0;
    logic [29:0] m_word = '0;
    logic [3:0]  m_be = '0;
    logic [31:0] m_data = '0;
    int          m_run = 0;
    bit          m_nm = 0;

    always #10 clk = ~clk;

    store_merge_latch i_store_merge_latch (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_no_merge(cfg_no_merge),
        .st_valid(st_valid), .st_ready(st_ready), .st_addr(st_addr), .st_be(st_be),
        .st_data(st_data), .st_cca(st_cca), .flush(flush), .fifo_ready(fifo_ready),
        .fifo_push(fifo_push), .fifo_addr(fifo_addr), .fifo_be(fifo_be),
        .fifo_data(fifo_data), .fifo_end(fifo_end)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] expv);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    task automatic enq(input logic endb, input string tag);
        exp_t x;
        x.a = {m_word, 2'b00}; x.b = m_be; x.d = m_data; x.e = endb; x.tag = tag;
        exp_q.push_back(x);
    endtask

    // Model of a store acceptance.
    task automatic model_store(input logic [31:0] a, input logic [3:0] b,
                               input logic [31:0] d, input logic [2:0] c, input string tag);
        logic [29:0] w;
        logic        endb;
        w = a[31:2];
        if (!m_v) begin
            m_v = 1; m_word = w; m_be = b; m_data = d;
        end else if (w == m_word && !m_nm && c != 3'd2) begin
            for (int i = 0; i < 4; i++) if (b[i]) m_data[8*i +: 8] = d[8*i +: 8];
            m_be = m_be | b;
        end else begin
            endb = !((w == m_word + 30'd1) && (m_word[2:0] != 3'd7) && (m_run < 7));
            enq(endb, tag);
            m_run = endb ? 0 : m_run + 1;
            m_word = w; m_be = b; m_data = d;
        end
    endtask

    task automatic do_store(input logic [31:0] a, input logic [3:0] b,
                            input logic [31:0] d, input logic [2:0] c, input string tag);
        @(posedge clk); #1;
        st_valid = 1; st_addr = a; st_be = b; st_data = d; st_cca = c;
        #2;
        while (!st_ready) begin
            @(posedge clk); #3;
        end
        model_store(a, b, d, c, tag);
        @(posedge clk); #1;
        st_valid = 0;
    endtask

    task automatic do_flush(input string tag);
        @(posedge clk); #1;
        flush = 1;
        #2;
        chk(st_ready == 1'b0, "R8 ready low in flush", st_ready, 0);
        if (m_v) begin
            enq(1'b1, tag);
            m_run = 0;
            m_v = 0;
        end else begin
            chk(fifo_push == 1'b0, "R8 empty flush pushes nothing", fifo_push, 0);
        end
        @(posedge clk); #1;
        flush = 0;
    endtask

    task automatic set_nm(input bit v);
        @(posedge clk); #1;
        cfg_we = 1; cfg_no_merge = v;
        @(posedge clk); #1;
        cfg_we = 0; m_nm = v;
    endtask

    // Monitor: compare every push against the scoreboard.
    always @(negedge clk) begin
        if (rst_n && fifo_push) begin
            if (exp_q.size() == 0) begin
                chk(0, "R10 unexpected push", fifo_addr, 0);
            end else begin
                exp_t x;
                x = exp_q.pop_front();
                chk(fifo_addr == x.a, {x.tag, " addr"}, fifo_addr, x.a);
                chk(fifo_be == x.b, {x.tag, " be"}, fifo_be, x.b);
                chk(fifo_data == x.d, {x.tag, " data"}, fifo_data, x.d);
                chk(fifo_end == x.e, {x.tag, " end"}, fifo_end, x.e);
            end
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
            $finish;
        end
    endtask

    initial begin
        #(20 * 200000);
        chk(0, "watchdog", 0, 1);
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        #2;
        // R1: reset state
        chk(st_ready == 1'b1, "R1 ready after reset", st_ready, 1);
        chk(fifo_push == 1'b0, "R1 no push after reset", fifo_push, 0);

        // R2 + R6: merge then sequential displacement
        do_store(32'h1000, 4'b0001, 32'h000000AB, 3'd0, "R2");
        do_store(32'h1000, 4'b0100, 32'h00CD0000, 3'd0, "R2");
        do_store(32'h1004, 4'b1111, 32'h11111111, 3'd0, "R2 R6 merged entry");
        do_flush("R8 flush");

        // R5: 0x1000, 0x1005, 0x1002 do not merge across the FIFO
        do_store(32'h1000, 4'b0001, 32'h000000AB, 3'd0, "R5");
        do_store(32'h1005, 4'b0010, 32'h0000CD00, 3'd0, "R5 R6 seq");
        do_store(32'h1002, 4'b0100, 32'h00DE0000, 3'd0, "R5 R6 nonseq");
        do_flush("R5 lone 0x1002");
        do_flush("R8 empty");

        // R4: attribute 2 blocks merge, attribute 3 merges
        do_store(32'h4000, 4'b0001, 32'h00000011, 3'd0, "R4");
        do_store(32'h4000, 4'b0010, 32'h00002200, 3'd2, "R4 cca2 displaces");
        do_store(32'h4000, 4'b0100, 32'h00330000, 3'd3, "R4 cca3 merges");
        do_flush("R4 merged");

        // R3: global no-merge
        set_nm(1);
        do_store(32'h4100, 4'b0001, 32'h00000044, 3'd0, "R3");
        do_store(32'h4100, 4'b0010, 32'h00005500, 3'd0, "R3 global displaces");
        do_flush("R3 second");
        set_nm(0);

        // R6 + R7: aligned eight-word run then boundary crossing
        for (int i = 0; i < 10; i++)
            do_store(32'h2000 + 32'(4 * i), 4'b1111, 32'hA0000000 + 32'(i), 3'd1, "R6 R7 run");
        do_flush("R7 tail");
        // unaligned run crossing the block edge
        for (int i = 0; i < 4; i++)
            do_store(32'h2038 + 32'(4 * i), 4'b1111, 32'hB0000000 + 32'(i), 3'd1, "R7 cross");
        do_flush("R7 tail2");

        // R9: stall on full FIFO, merge still accepted
        do_store(32'h6000, 4'b0001, 32'h00000001, 3'd0, "R9");
        @(posedge clk); #1;
        fifo_ready = 0;
        do_store(32'h6000, 4'b1000, 32'h02000000, 3'd0, "R9 merge while full");
        @(posedge clk); #1;
        st_valid = 1; st_addr = 32'h6004; st_be = 4'b1111; st_data = 32'hCAFEF00D; st_cca = 3'd0;
        for (int k = 0; k < 3; k++) begin
            #2;
            chk(st_ready == 1'b0, "R9 stall", st_ready, 0);
            chk(fifo_push == 1'b0, "R9 no push while full", fifo_push, 0);
            @(posedge clk); #1;
        end
        fifo_ready = 1;
        #2;
        chk(st_ready == 1'b1, "R9 released", st_ready, 1);
        model_store(32'h6004, 4'b1111, 32'hCAFEF00D, 3'd0, "R9 displaced");
        @(posedge clk); #1;
        st_valid = 0;

        // R10: idle cycles keep the entry
        repeat (6) @(posedge clk);
        #2;
        chk(fifo_push == 1'b0, "R10 idle no push", fifo_push, 0);
        do_flush("R10 held entry");

        repeat (3) @(posedge clk);
        chk(exp_q.size() == 0, "R10 scoreboard drained", exp_q.size(), 0);
        finish_run();
    end
endmodule